// File: doc/BRIEF.md
# Loop Controller Signal/Wait Synchronizer and Instruction Merge

This block sits between a group of parallel loop sequencers and the control decode that follows them. In every cycle each sequencer offers one instruction class together with a control word. The classes are: nothing, emit a word, wait for a release, or release another sequencer by number. The block decides in the same cycle whether each sequencer's current instruction has completed, and it tells the sequencer through a per-port advance strobe. It also ORs the words of every active sequencer into a single instruction word for the downstream path.

Releases are non-blocking. The sequencer that issues a release always moves on at once. The release is stored as a one-bit pending mark at its target. If the target is already waiting, the mark frees it in the next cycle. If the target is not yet waiting, its next wait finishes in a single cycle and emits its word once. A mark never counts higher than one. A waiting sequencer keeps putting its wait word into the merge every cycle until it is released. Idle sequencers put in nothing.

Top module: `loopsync_hub`

## Requirements
- R1: Each port n takes a 2-bit class at op_i[2n+1:2n] (00 idle, 01 emit, 10 wait, 11 release), a target number at tgt_i[ID_W*n +: ID_W] and a word at word_i[WORD_W*n +: WORD_W]; an idle port never raises its advance bit.
- R2: merged_o is the bitwise OR of the words of all ports whose class is not idle, and is zero when every port is idle.
- R3: An emit completes in the cycle it is presented (advance bit high).
- R4: A release completes in the cycle it is presented, and its word is merged like any other word.
- R5: A wait with no pending mark holds (advance low) and its word stays in the merge in every held cycle.
- R6: A release aimed at a port that is not waiting is remembered; that port's next wait completes in its first cycle, emitting its word once, and a later wait holds again.
- R7: A release aimed at a port that is waiting in that cycle lets the wait complete in the following cycle.
- R8: The pending mark saturates at one: two releases before a wait skip only one wait.
- R9: Releases issued in the same cycle by different ports to different targets all take effect.
- R10: A release that arrives in the same cycle as a wait consumes the pending mark leaves the mark set for the next wait.
- R11: Reset clears every pending mark, so a wait presented after reset holds even if a release arrived before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 2*NCTL | Instruction class per port |
| tgt_i | input | ID_W*NCTL | Release target number per port |
| word_i | input | WORD_W*NCTL | Control word per port |
| adv_o | output | NCTL | Per-port completion strobe |
| merged_o | output | WORD_W | OR of all active ports' words |

## Verification
Two functions can act on the same pending mark in one cycle: the consumption by a completing wait and the setting by a new release. The bench first leaves a mark at one port. It then presents that port's wait while a second port releases it in the same cycle. The consuming wait must complete, and the next wait must complete as well, because the mark was not lost. A further wait must then hold. Several releases landing in one cycle, both to different targets and twice to the same target, are judged the same way by the advance strobes of the waits that follow.

// File: rtl/loopsync_pkg.sv
package loopsync_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_EMIT = 2'b01,
    OP_WAIT = 2'b10,
    OP_REL  = 2'b11
  } ctl_op_e;
endpackage

// File: rtl/loopsync_decode.sv
module loopsync_decode
  import loopsync_pkg::*;
(
  input  ctl_op_e op,
  input  logic    pend,
  output logic    adv,
  output logic    word_en,
  output logic    rel_en,
  output logic    consume
);
  always_comb begin
    word_en = (op != OP_IDLE);
    rel_en  = (op == OP_REL);
    consume = (op == OP_WAIT) && pend;
    adv     = (op == OP_EMIT) || (op == OP_REL) || consume;
  end
endmodule

// File: rtl/loopsync_route.sv
module loopsync_route #(
  parameter int NCTL = 4,
  parameter int ID_W = 2
) (
  input  logic [NCTL-1:0]      rel_en,
  input  logic [NCTL*ID_W-1:0] tgt,
  output logic [NCTL-1:0]      hit
);
  always_comb begin
    hit = '0;
    for (int src = 0; src < NCTL; src++) begin
      if (rel_en[src]) begin
        for (int dst = 0; dst < NCTL; dst++) begin
          if (tgt[src*ID_W +: ID_W] == ID_W'(dst)) hit[dst] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/loopsync_pend.sv
module loopsync_pend #(
  parameter int NCTL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTL-1:0] hit,
  input  logic [NCTL-1:0] consume,
  output logic [NCTL-1:0] pend_q
);
  logic [NCTL-1:0] pend_d;
  logic [NCTL-1:0] pend_en;

  always_comb begin
    for (int n = 0; n < NCTL; n++) begin
      pend_en[n] = hit[n] | consume[n];
      // a new release wins over a consumption in the same cycle
      pend_d[n]  = hit[n];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCTL; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q[g] <= 1'b0;
        else if (pend_en[g]) pend_q[g] <= pend_d[g];
      end
    end
  endgenerate
endmodule

// File: rtl/loopsync_merge.sv
module loopsync_merge #(
  parameter int NCTL   = 4,
  parameter int WORD_W = 8
) (
  input  logic [NCTL*WORD_W-1:0] words,
  input  logic [NCTL-1:0]        word_en,
  output logic [WORD_W-1:0]      merged
);
  logic [WORD_W-1:0] gated [NCTL];

  genvar g;
  generate
    for (g = 0; g < NCTL; g++) begin : g_gate
      assign gated[g] = word_en[g] ? words[g*WORD_W +: WORD_W] : '0;
    end
  endgenerate

  always_comb begin
    merged = '0;
    for (int n = 0; n < NCTL; n++) merged = merged | gated[n];
  end
endmodule

// File: rtl/loopsync_hub.sv
module loopsync_hub
  import loopsync_pkg::*;
#(
  parameter int NCTL   = 4,
  parameter int WORD_W = 8,
  localparam int ID_W  = (NCTL > 1) ? $clog2(NCTL) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NCTL-1:0]      op_i,
  input  logic [ID_W*NCTL-1:0]   tgt_i,
  input  logic [WORD_W*NCTL-1:0] word_i,
  output logic [NCTL-1:0]        adv_o,
  output logic [WORD_W-1:0]      merged_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_sync_n;
  logic [NCTL-1:0] pend_w;
  logic [NCTL-1:0] word_en;
  logic [NCTL-1:0] rel_en;
  logic [NCTL-1:0] consume;
  logic [NCTL-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  genvar g;
  generate
    for (g = 0; g < NCTL; g++) begin : g_port
      loopsync_decode u_dec (
        .op      (ctl_op_e'(op_i[2*g +: 2])),
        .pend    (pend_w[g]),
        .adv     (adv_o[g]),
        .word_en (word_en[g]),
        .rel_en  (rel_en[g]),
        .consume (consume[g])
      );
    end
  endgenerate

  loopsync_route #(.NCTL(NCTL), .ID_W(ID_W)) u_route (
    .rel_en (rel_en),
    .tgt    (tgt_i),
    .hit    (hit)
  );

  loopsync_pend #(.NCTL(NCTL)) u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hit     (hit),
    .consume (consume),
    .pend_q  (pend_w)
  );

  loopsync_merge #(.NCTL(NCTL), .WORD_W(WORD_W)) u_merge (
    .words   (word_i),
    .word_en (word_en),
    .merged  (merged_o)
  );
endmodule

// File: rtl/loopsync_hub_chk.sv
module loopsync_hub_chk #(
  parameter int NCTL   = 4,
  parameter int WORD_W = 8,
  parameter int ID_W   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2*NCTL-1:0]    op_i,
  input logic [ID_W*NCTL-1:0] tgt_i,
  input logic [NCTL-1:0]      adv_o,
  input logic [WORD_W-1:0]    merged_o,
  input logic [NCTL-1:0]      pend
);
  logic [NCTL-1:0] aimed;
  always_comb begin
    aimed = '0;
    for (int s = 0; s < NCTL; s++)
      for (int d = 0; d < NCTL; d++)
        if (op_i[2*s +: 2] == 2'b11 && tgt_i[s*ID_W +: ID_W] == ID_W'(d)) aimed[d] = 1'b1;
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == '0) |-> (merged_o == '0)); // R2

  genvar g;
  generate
    for (g = 0; g < NCTL; g++) begin : g_chk
      AST_IDLE_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2*g +: 2] == 2'b00) |-> !adv_o[g]); // R1
      AST_EMIT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2*g +: 2] == 2'b01) |-> adv_o[g]); // R3
      AST_REL_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2*g +: 2] == 2'b11) |-> adv_o[g]); // R4
      AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2*g +: 2] == 2'b10 && !pend[g]) |-> !adv_o[g]); // R5
      AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        aimed[g] |=> (op_i[2*g +: 2] != 2'b10 || adv_o[g])); // R7
      AST_MARK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        aimed[g] |=> pend[g]); // R10
    end
  endgenerate
endmodule

bind loopsync_hub loopsync_hub_chk #(.NCTL(NCTL), .WORD_W(WORD_W), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .op_i     (op_i),
  .tgt_i    (tgt_i),
  .adv_o    (adv_o),
  .merged_o (merged_o),
  .pend     (pend_w)
);

// File: tb/loopsync_hub_test.sv
module loopsync_hub_test;
  localparam int PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op_i = '0;
  logic [7:0]  tgt_i = '0;
  logic [31:0] word_i = '0;
  logic [3:0]  adv_o;
  logic [7:0]  merged_o;
  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  loopsync_hub uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .tgt_i(tgt_i),
    .word_i(word_i), .adv_o(adv_o), .merged_o(merged_o)
  );

  // {ops, targets, words, expected advance, expected merge}
  localparam logic [59:0] VEC [NV] = '{
    {8'h00, 8'h00, 32'hFFFFFFFF, 4'h0, 8'h00}, // R2 all idle
    {8'h05, 8'h00, 32'hAABB1001, 4'h3, 8'h11}, // R3 R1 two emits
    {8'h09, 8'h00, 32'h00002002, 4'h1, 8'h22}, // R5 port1 waits
    {8'h38, 8'h10, 32'h00042000, 4'h4, 8'h24}, // R4 port2 releases port1
    {8'h08, 8'h00, 32'h00002000, 4'h2, 8'h20}, // R7 port1 freed
    {8'hC0, 8'h00, 32'h40000000, 4'h8, 8'h40}, // R6 release idle port0
    {8'h01, 8'h00, 32'h00000001, 4'h1, 8'h01}, // R6 port0 emits
    {8'h02, 8'h00, 32'h00000080, 4'h1, 8'h80}, // R6 wait skipped
    {8'h02, 8'h00, 32'h00000080, 4'h0, 8'h80}, // R6 next wait holds
    {8'hCC, 8'h88, 32'h08000400, 4'hA, 8'h0C}, // R8 two releases to port2
    {8'h20, 8'h00, 32'h00100000, 4'h4, 8'h10}, // R8 one skip
    {8'h20, 8'h00, 32'h00100000, 4'h0, 8'h10}, // R8 second wait holds
    {8'h2F, 8'h0B, 32'h00100201, 4'h3, 8'h13}, // R9 two releases
    {8'hA0, 8'h00, 32'h20100000, 4'hC, 8'h30}, // R9 both freed
    {8'h03, 8'h01, 32'h00000001, 4'h1, 8'h01}, // R10 mark port1
    {8'h0B, 8'h01, 32'h00000201, 4'h3, 8'h03}, // R10 consume and set together
    {8'h08, 8'h00, 32'h00000200, 4'h2, 8'h02}, // R10 mark kept
    {8'h08, 8'h00, 32'h00000200, 4'h0, 8'h02}  // R10 then holds
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] o, input logic [7:0] t, input logic [31:0] w);
    @(negedge clk);
    op_i = o; tgt_i = t; word_i = w;
    #(PERIOD/2 - 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R11 reset adv", {4'h0, adv_o}, 8'h00);
    check("R11 reset merge", merged_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][59:52], VEC[i][51:44], VEC[i][43:12]);
      check($sformatf("vec%0d adv", i), {4'h0, adv_o}, {4'h0, VEC[i][11:8]});
      check($sformatf("vec%0d merge", i), merged_o, VEC[i][7:0]);
    end

    // R11: a mark left before reset is cleared
    apply(8'h03, 8'h03, 32'h0);
    check("R11 release strobe", {4'h0, adv_o}, 8'h01);
    @(negedge clk); op_i = '0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(8'h80, 8'h00, 32'h20000000);
    check("R11 wait after reset holds", {4'h0, adv_o}, 8'h00);
    check("R11 wait word merged", merged_o, 8'h20);
    apply(8'h83, 8'h03, 32'h20000001);
    check("R7 release while waiting", {4'h0, adv_o}, 8'h01);
    apply(8'h80, 8'h00, 32'h20000000);
    check("R7 freed next cycle", {4'h0, adv_o}, 8'h08);
    apply(8'h00, 8'h00, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule